// File: doc/BRIEF.md
# Register Rename Unit with Rollback

This block is the rename stage of an out-of-order core. Each cycle it can accept one decoded instruction in program order. The instruction carries two source register names and, optionally, one destination name. For each source the unit returns the physical register that currently holds that name. If there is a destination, it returns a freshly allocated physical register and also the physical register that the destination name pointed to before. That previous register is remembered so it can be released later.

Three structures cooperate:

- An alias table maps each of the 8 architectural names to one of 16 physical registers.
- A free pool holds the physical registers that are not in use.
- An 8-entry in-flight queue records, in program order, every renamed instruction together with its new and previous destination registers.

A commit request retires the oldest queue entry and sends its previous register back to the free pool. A flush request squashes the youngest entries of the queue. The unit then spends one cycle per squashed entry, youngest first, putting each saved mapping back into the alias table and returning each allocated register to the free pool. While this recovery runs, `busy` is high and no instruction or commit is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, `busy` is 0, and the first eight allocations hand out physical registers 8, 9, …, 15 in ascending order.
- R2: Both source tags of an instruction are read from the alias table as it stood before that instruction's own destination is remapped, so an instruction that writes R1 and reads R1 twice gets the old tag on both sources.
- R3: A destination tag is taken from the head of the free pool. Released registers join the pool at its tail, so the pool is first-in first-out. `rn_old_tag` reports the previous mapping of the destination, so successive writers of one name get distinct tags. A reader renamed between two writers gets the first writer's tag.
- R4: On an accepted commit (`commit_valid` while the queue is non-empty, `busy` is 0 and `flush_valid` is 0), the oldest entry retires. If that entry has a destination, `retire_free_valid` is 1 and `retire_free_tag` is its previous tag, which re-enters the pool; its new tag is never freed. Entries without a destination retire with `retire_free_valid` 0. In every other case, including an empty queue, `commit_valid` has no effect.
- R5: An instruction with a destination is not accepted (`in_ready` 0) while the free pool is empty.
- R6: No instruction is accepted while the in-flight queue holds 8 entries. Instructions without a destination still occupy an entry.
- R7: `flush_valid` with `busy` at 0 squashes the youngest min(`flush_count`, occupancy) entries. `busy` is then 1 for exactly that many cycles. During those cycles, and in the flush cycle itself, `in_ready` is 0 and commits are ignored. Afterwards the alias table is as it was before the squashed instructions, and the next allocations reuse their registers in the same order. A flush while `busy` is 1 is ignored.
- R8: Every physical register is always in exactly one place: the free pool, the alias table, or a saved previous tag in the queue. After the queue drains, the 8 mapped tags and the 8 tags allocatable before a stall are 16 distinct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered for rename |
| in_src_a | input | 3 | First source architectural register |
| in_src_b | input | 3 | Second source architectural register |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_dst | input | 3 | Destination architectural register |
| in_ready | output | 1 | Unit accepts the offered instruction this cycle |
| rn_src_a_tag | output | 4 | Physical tag of the first source |
| rn_src_b_tag | output | 4 | Physical tag of the second source |
| rn_dst_tag | output | 4 | Newly allocated destination tag (meaningful with a destination) |
| rn_old_tag | output | 4 | Previous physical tag of the destination |
| commit_valid | input | 1 | Retire the oldest in-flight entry |
| retire_free_valid | output | 1 | A previous tag is released this cycle |
| retire_free_tag | output | 4 | The released tag |
| flush_valid | input | 1 | Squash the youngest entries |
| flush_count | input | 4 | Number of youngest entries to squash (clipped to occupancy) |
| busy | output | 1 | Rollback in progress |

## Verification
The embedded assertions check the following on every cycle:

- register conservation, expressed as free-pool count plus in-flight destination entries equalling 8;
- that the pool is never popped when empty and the queue is never pushed when full;
- that a rollback step never coincides with a push or a commit;
- that a fresh destination tag never equals the tag it replaces.

Only the bench scenarios can show that the actual tag values are correct. This covers the read-before-write order for an instruction that names one register three times, the first-in first-out reuse of released registers, and the exact restored mappings and reused tags after a partial flush. These scenarios are checked against a spec-level model of the table, pool and queue across directed sequences and a long pseudo-random sweep.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int NUM_ARCH  = 8;
    localparam int NUM_PHYS  = 16;
    localparam int Q_DEPTH   = 8;
    localparam int AW        = $clog2(NUM_ARCH);
    localparam int PW        = $clog2(NUM_PHYS);
    localparam int QW        = $clog2(Q_DEPTH);
    localparam int FL_CW     = PW + 1;
    localparam int QCW       = QW + 1;
    localparam int FREE_INIT = NUM_PHYS - NUM_ARCH;

    typedef logic [AW-1:0] areg_t;
    typedef logic [PW-1:0] ptag_t;

    typedef struct packed {
        logic  has_dst;
        areg_t dst;
        ptag_t new_tag;
        ptag_t old_tag;
    } inflight_t;
endpackage

// File: rtl/rename_alias_table.sv
module rename_alias_table
    import rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  areg_t rd_a_i,
    input  areg_t rd_b_i,
    input  areg_t rd_d_i,
    output ptag_t tag_a_o,
    output ptag_t tag_b_o,
    output ptag_t tag_d_o,
    input  logic  wr_en_i,
    input  areg_t wr_arch_i,
    input  ptag_t wr_tag_i
);
    typedef struct packed {
        ptag_t [NUM_ARCH-1:0] map;
    } rat_state_t;

    rat_state_t s_q, s_d;

    // Reads come from the registered table: a write this cycle is seen next cycle (R2).
    assign tag_a_o = s_q.map[rd_a_i];
    assign tag_b_o = s_q.map[rd_b_i];
    assign tag_d_o = s_q.map[rd_d_i];

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.map[wr_arch_i] = wr_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                s_q.map[i] <= PW'(i);
            end
        end else begin
            s_q <= s_d;
        end
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (s_q.map[$past(wr_arch_i)] == $past(wr_tag_i)));
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
    import rename_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    output ptag_t            head_tag_o,
    output logic [FL_CW-1:0] count_o,
    input  logic             push_back_i,
    input  ptag_t            push_back_tag_i,
    input  logic             push_front_i,
    input  ptag_t            push_front_tag_i
);
    typedef struct packed {
        ptag_t [NUM_PHYS-1:0] slot;
        logic [PW-1:0]        head;
        logic [PW-1:0]        tail;
        logic [FL_CW-1:0]     count;
    } fl_state_t;

    fl_state_t     s_q, s_d;
    logic [PW-1:0] head_m1;

    assign head_tag_o = s_q.slot[s_q.head];
    assign count_o    = s_q.count;
    assign head_m1    = s_q.head - 1'b1;

    always_comb begin
        s_d = s_q;
        if (pop_i) begin
            s_d.head = s_q.head + 1'b1;
        end
        if (push_front_i) begin
            s_d.head          = head_m1;
            s_d.slot[head_m1] = push_front_tag_i;
        end
        if (push_back_i) begin
            s_d.slot[s_q.tail] = push_back_tag_i;
            s_d.tail           = s_q.tail + 1'b1;
        end
        s_d.count = s_q.count + FL_CW'(push_back_i) + FL_CW'(push_front_i) - FL_CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                s_q.slot[i] <= (i < FREE_INIT) ? PW'(NUM_ARCH + i) : '0;
            end
            s_q.head  <= '0;
            s_q.tail  <= PW'(FREE_INIT);
            s_q.count <= FL_CW'(FREE_INIT);
        end else begin
            s_q <= s_d;
        end
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.count != '0));
    p_no_overfill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_back_i || push_front_i) |-> (s_q.count < FL_CW'(NUM_PHYS)));
endmodule

// File: rtl/rename_inflight_queue.sv
module rename_inflight_queue
    import rename_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  inflight_t      push_entry_i,
    input  logic           pop_head_i,
    output inflight_t      head_entry_o,
    input  logic           pop_tail_i,
    output inflight_t      tail_entry_o,
    output logic [QCW-1:0] count_o,
    output logic [QCW-1:0] dst_count_o
);
    typedef struct packed {
        inflight_t [Q_DEPTH-1:0] slot;
        logic [QW-1:0]           head;
        logic [QW-1:0]           tail;
        logic [QCW-1:0]          count;
        logic [QCW-1:0]          dst_cnt;
    } q_state_t;

    q_state_t      s_q, s_d;
    logic [QW-1:0] tail_m1;

    assign tail_m1      = s_q.tail - 1'b1;
    assign head_entry_o = s_q.slot[s_q.head];
    assign tail_entry_o = s_q.slot[tail_m1];
    assign count_o      = s_q.count;
    assign dst_count_o  = s_q.dst_cnt;

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            s_d.slot[s_q.tail] = push_entry_i;
            s_d.tail           = s_q.tail + 1'b1;
        end
        if (pop_head_i) begin
            s_d.head = s_q.head + 1'b1;
        end
        if (pop_tail_i) begin
            s_d.tail = tail_m1;
        end
        s_d.count = s_q.count + QCW'(push_i) - QCW'(pop_head_i) - QCW'(pop_tail_i);
        s_d.dst_cnt = s_q.dst_cnt
                    + QCW'(push_i && push_entry_i.has_dst)
                    - QCW'(pop_head_i && head_entry_o.has_dst)
                    - QCW'(pop_tail_i && tail_entry_o.has_dst);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_push_not_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (s_q.count < QCW'(Q_DEPTH)));
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_head_i || pop_tail_i) |-> (s_q.count != '0));
    p_undo_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_tail_i |-> (!push_i && !pop_head_i));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [AW-1:0]  in_src_a,
    input  logic [AW-1:0]  in_src_b,
    input  logic           in_has_dst,
    input  logic [AW-1:0]  in_dst,
    output logic           in_ready,
    output logic [PW-1:0]  rn_src_a_tag,
    output logic [PW-1:0]  rn_src_b_tag,
    output logic [PW-1:0]  rn_dst_tag,
    output logic [PW-1:0]  rn_old_tag,
    input  logic           commit_valid,
    output logic           retire_free_valid,
    output logic [PW-1:0]  retire_free_tag,
    input  logic           flush_valid,
    input  logic [QCW-1:0] flush_count,
    output logic           busy
);
    typedef struct packed {
        logic           busy;
        logic [QCW-1:0] remain;
    } ctl_state_t;

    ctl_state_t       ctl_q, ctl_d;
    ptag_t            fl_head;
    logic [FL_CW-1:0] fl_count;
    logic [QCW-1:0]   q_count, q_dst_count, flush_k;
    inflight_t        head_entry, tail_entry, new_entry;
    logic             accept, alloc, commit_ok, undo, undo_dst;
    logic             rat_we;
    areg_t            rat_wr_arch;
    ptag_t            rat_wr_tag;

    assign busy      = ctl_q.busy;
    assign undo      = ctl_q.busy;
    assign undo_dst  = undo && tail_entry.has_dst;
    assign in_ready  = !ctl_q.busy && !flush_valid && (q_count < QCW'(Q_DEPTH))
                     && (!in_has_dst || (fl_count != '0));
    assign accept    = in_valid && in_ready;
    assign alloc     = accept && in_has_dst;
    assign commit_ok = commit_valid && !ctl_q.busy && !flush_valid && (q_count != '0);
    assign flush_k   = (flush_count > q_count) ? q_count : flush_count;

    assign rn_dst_tag        = fl_head;
    assign retire_free_valid = commit_ok && head_entry.has_dst;
    assign retire_free_tag   = head_entry.old_tag;

    always_comb begin
        new_entry.has_dst = in_has_dst;
        new_entry.dst     = in_dst;
        new_entry.new_tag = in_has_dst ? fl_head : '0;
        new_entry.old_tag = in_has_dst ? rn_old_tag : '0;
    end

    // Rollback and rename never share a cycle, so one write port suffices.
    always_comb begin
        rat_we      = undo_dst || alloc;
        rat_wr_arch = undo_dst ? tail_entry.dst : in_dst;
        rat_wr_tag  = undo_dst ? tail_entry.old_tag : fl_head;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.busy) begin
            ctl_d.remain = ctl_q.remain - 1'b1;
            ctl_d.busy   = (ctl_q.remain != QCW'(1));
        end else if (flush_valid && (flush_k != '0)) begin
            ctl_d.busy   = 1'b1;
            ctl_d.remain = flush_k;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rename_alias_table u_rat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_i    (in_src_a),
        .rd_b_i    (in_src_b),
        .rd_d_i    (in_dst),
        .tag_a_o   (rn_src_a_tag),
        .tag_b_o   (rn_src_b_tag),
        .tag_d_o   (rn_old_tag),
        .wr_en_i   (rat_we),
        .wr_arch_i (rat_wr_arch),
        .wr_tag_i  (rat_wr_tag)
    );

    rename_free_list u_free (
        .clk              (clk),
        .rst_n            (rst_n),
        .pop_i            (alloc),
        .head_tag_o       (fl_head),
        .count_o          (fl_count),
        .push_back_i      (retire_free_valid),
        .push_back_tag_i  (head_entry.old_tag),
        .push_front_i     (undo_dst),
        .push_front_tag_i (tail_entry.new_tag)
    );

    rename_inflight_queue u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (accept),
        .push_entry_i (new_entry),
        .pop_head_i   (commit_ok),
        .head_entry_o (head_entry),
        .pop_tail_i   (undo),
        .tail_entry_o (tail_entry),
        .count_o      (q_count),
        .dst_count_o  (q_dst_count)
    );

    p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fl_count) + 32'(q_dst_count)) == FREE_INIT);
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!in_ready && !retire_free_valid));
    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (rn_dst_tag != rn_old_tag));
    p_stall_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0 && in_has_dst) |-> !in_ready);
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_has_dst, commit_valid, flush_valid;
    logic [2:0] in_src_a, in_src_b, in_dst;
    logic [3:0] flush_count;
    logic       in_ready, retire_free_valid, busy;
    logic [3:0] rn_src_a_tag, rn_src_b_tag, rn_dst_tag, rn_old_tag, retire_free_tag;

    int checks = 0;
    int fails  = 0;

    // Spec model
    int  m_rat [8];
    int  m_fl[$];
    int  qh[$], qd[$], qn[$], qo[$];
    bit  m_busy;
    int  m_rem;

    always #2.5 clk = ~clk;

    rename_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_has_dst(in_has_dst), .in_dst(in_dst),
        .in_ready(in_ready), .rn_src_a_tag(rn_src_a_tag), .rn_src_b_tag(rn_src_b_tag),
        .rn_dst_tag(rn_dst_tag), .rn_old_tag(rn_old_tag), .commit_valid(commit_valid),
        .retire_free_valid(retire_free_valid), .retire_free_tag(retire_free_tag),
        .flush_valid(flush_valid), .flush_count(flush_count), .busy(busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One cycle: drive at negedge, check before the next posedge, update the model.
    task automatic step(input string tag, input bit v, input int a, input int b,
                        input bit hd, input int d, input bit cv, input bit fv, input int fc);
        bit exp_ready, cok, acc;
        int k, last, nt;
        @(negedge clk);
        in_valid = v; in_src_a = 3'(a); in_src_b = 3'(b); in_has_dst = hd; in_dst = 3'(d);
        commit_valid = cv; flush_valid = fv; flush_count = 4'(fc);
        #1;
        exp_ready = !m_busy && !fv && (qh.size() < 8) && (!hd || m_fl.size() > 0);
        chk(tag, "in_ready", int'(in_ready), int'(exp_ready));
        chk(tag, "busy", int'(busy), int'(m_busy));
        acc = v && exp_ready;
        if (acc) begin
            chk(tag, "src_a tag", int'(rn_src_a_tag), m_rat[a]);
            chk(tag, "src_b tag", int'(rn_src_b_tag), m_rat[b]);
            if (hd) begin
                chk(tag, "dst tag", int'(rn_dst_tag), m_fl[0]);
                chk(tag, "old tag", int'(rn_old_tag), m_rat[d]);
            end
        end
        cok = cv && !m_busy && !fv && (qh.size() > 0);
        chk(tag, "retire_free_valid", int'(retire_free_valid), int'(cok && qh[0] == 1));
        if (cok && qh[0] == 1) chk(tag, "retire_free_tag", int'(retire_free_tag), qo[0]);
        // model update
        if (m_busy) begin
            last = qh.size() - 1;
            if (qh[last] == 1) begin
                m_rat[qd[last]] = qo[last];
                m_fl.push_front(qn[last]);
            end
            void'(qh.pop_back()); void'(qd.pop_back()); void'(qn.pop_back()); void'(qo.pop_back());
            m_rem--;
            if (m_rem == 0) m_busy = 0;
        end else if (fv) begin
            k = (fc > qh.size()) ? qh.size() : fc;
            if (k > 0) begin m_busy = 1; m_rem = k; end
        end
        if (cok) begin
            if (qh[0] == 1) m_fl.push_back(qo[0]);
            void'(qh.pop_front()); void'(qd.pop_front()); void'(qn.pop_front()); void'(qo.pop_front());
        end
        if (acc) begin
            if (hd) begin
                nt = m_fl.pop_front();
                qh.push_back(1); qd.push_back(d); qn.push_back(nt); qo.push_back(m_rat[d]);
                m_rat[d] = nt;
            end else begin
                qh.push_back(0); qd.push_back(0); qn.push_back(0); qo.push_back(0);
            end
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain(input string tag);
        while (qh.size() > 0 || m_busy) step(tag, 0, 0, 0, 0, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        logic [15:0] mask;
        int a0, b0, tg;
        r = 32'h1234_5678;
        rst_n = 0; in_valid = 0; in_src_a = 0; in_src_b = 0; in_has_dst = 0; in_dst = 0;
        commit_valid = 0; flush_valid = 0; flush_count = 0;
        for (int i = 0; i < 8; i++) m_rat[i] = i;
        for (int i = 8; i < 16; i++) m_fl.push_back(i);
        m_busy = 0; m_rem = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: identity mapping at reset, every source pair
        for (int i = 0; i < 8; i++) step("R1", 1, i, 7 - i, 0, 0, 1, 0, 0);
        drain("R1");
        // R1: first allocations come out 8..15 ascending; R6 stall once full
        for (int i = 0; i < 8; i++) begin
            step("R1", 1, i, i, 1, i, 0, 0, 0);
            chk("R1", "ascending alloc", int'(rn_dst_tag), 8 + i);
        end
        // R5 / R6: free pool empty and queue full -> stall, with and without dst
        step("R5", 1, 0, 1, 1, 2, 0, 0, 0);
        step("R6", 1, 0, 1, 0, 0, 0, 0, 0);
        // R4: commits release previous tags 0..7 in order
        for (int i = 0; i < 8; i++) begin
            step("R4", 0, 0, 0, 0, 0, 1, 0, 0);
            chk("R4", "released old tag", int'(retire_free_tag), i);
        end
        // R4: commit on empty queue ignored
        step("R4", 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R4", "empty commit no free", int'(retire_free_valid), 0);

        // R2: R1 = R1 + R1 reads the old tag on both sources
        a0 = m_rat[1];
        step("R2", 1, 1, 1, 1, 1, 0, 0, 0);
        chk("R2", "src_a before remap", int'(rn_src_a_tag), a0);
        chk("R2", "src_b before remap", int'(rn_src_b_tag), a0);
        // R3: writer, reader, writer chain on R1
        step("R3", 1, 2, 3, 1, 1, 0, 0, 0);
        tg = int'(rn_dst_tag);
        step("R3", 1, 1, 4, 0, 0, 0, 0, 0);
        chk("R3", "reader keeps first writer tag", int'(rn_src_a_tag), tg);
        step("R3", 1, 5, 6, 1, 1, 0, 0, 0);
        chk("R3", "second writer differs", int'(rn_dst_tag != tg), 1);
        chk("R3", "second writer old", int'(rn_old_tag), tg);
        // R4: no-dst retire frees nothing
        drain("R4");

        // R6: queue full of no-dst entries blocks even though pool is non-empty
        for (int i = 0; i < 8; i++) step("R6", 1, i, i, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 0, 1, 3, 0, 0, 0);
        step("R6", 1, 0, 0, 1, 3, 1, 0, 0);
        drain("R6");

        // R7: rename 5 writers, squash youngest 3; commit in flush cycle ignored
        for (int i = 0; i < 5; i++) step("R7", 1, i, i, 1, i % 3, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 0, 1, 1, 3);
        step("R7", 1, 0, 0, 1, 0, 1, 1, 5);   // flush while busy ignored
        step("R7", 1, 0, 0, 1, 0, 1, 0, 0);
        step("R7", 1, 0, 0, 1, 0, 0, 0, 0);
        // restored mapping and tag reuse
        for (int i = 0; i < 8; i++) step("R7", 1, i, 7 - i, 1, i, 0, 0, 0);
        // R7: oversize flush clipped to occupancy
        step("R7", 0, 0, 0, 0, 0, 0, 1, 15);
        idle("R7", 10);
        for (int i = 0; i < 8; i++) step("R7", 1, i, (i + 3) % 8, 0, 0, 1, 0, 0);
        drain("R7");

        // R3: pseudo-random sweep against the model
        for (int n = 0; n < 4000; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            step("R3", r[0] | r[1], int'(r[4:2]), int'(r[7:5]), r[8] | r[9], int'(r[12:10]),
                 r[13], r[20:16] == 5'd0, int'(r[24:21]));
        end
        drain("R8");

        // R8: mapped tags plus allocatable tags form all 16 registers
        mask = '0;
        for (int i = 0; i < 8; i++) begin
            step("R8", 1, i, i, 0, 0, 1, 0, 0);
            mask[rn_src_a_tag] = 1'b1;
        end
        drain("R8");
        for (int i = 0; i < 8; i++) begin
            step("R8", 1, 0, 0, 1, i, 0, 0, 0);
            mask[rn_dst_tag] = 1'b1;
        end
        step("R8", 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R8", "ninth alloc stalls", int'(in_ready), 0);
        chk("R8", "distinct tags", $countones(mask), 16);
        drain("R8");
        summary();
    end
endmodule